// File: doc/BRIEF.md
# Radix-3 carry-lookahead adder

A 27-bit combinational binary adder whose carries come from a lookahead tree in which every node has three children. Each leaf is a one-bit cell: it forms a bit-propagate (`a ^ b`) and a bit-generate (`a & b`) from its operand bits. It adds the carry that its parent node hands down to produce its sum bit.

A lookahead node takes the propagate/generate pairs of its three children and the carry into its lowest child. It passes that carry straight to the lowest child. It computes the carries into the middle and top children, and it reports a group propagate/generate pair upward. Three levels of nodes cover the word: nine nodes over 3-bit groups, three nodes over 9-bit groups, and one root over the whole word. The external carry-in enters at the root. The carry-out is formed from the root's group pair and that carry-in.

The block has no clock and no state. Outputs follow the operands and carry-in after the logic settles.

Top module: `tri_cla_adder`

## Requirements
- R1: `sum` equals bits 26..0 of the integer `a + b + cin`, for every operand pair and either carry-in value.
- R2: `cout` equals bit 27 of the integer `a + b + cin`.
- R3: With both operands zero and `cin` = 0, `sum` is zero and `cout` is 0.
- R4: With `a` all ones, `b` zero and `cin` = 1, `sum` is zero and `cout` is 1. The carry crosses every level of the tree.
- R5: A carry generated inside a 3-bit group reaches the next group. For each boundary k in {3, 6, ..., 24}, the carry into bit k equals bit k of `(a[k-1:0] + b[k-1:0] + cin)`.
- R6: A carry generated inside a 9-bit group reaches the next 9-bit group: the carry into bits 9 and 18 is correct by the same rule as R5.
- R7: When every bit position propagates (`a ^ b` all ones), `cout` equals `cin`. `sum` is all ones when `cin` = 0 and zero when `cin` = 1.
- R8: The block is purely combinational: `sum` and `cout` change after an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 27 | First operand |
| b | input | 27 | Second operand |
| cin | input | 1 | Carry into bit 0, fed to the root node |
| sum | output | 27 | Sum bits |
| cout | output | 1 | Carry out of bit 26, formed at the root |

## Verification
The assertions are evaluated every time any input changes:
- the whole-word sum and carry-out against integer addition;
- the carry into every 3-bit and 9-bit group boundary against a partial sum of the lower bits;
- the rule that a fully propagating word passes the carry-in straight to the carry-out.

Only the bench's scenarios show that particular operand patterns occur. These include the full-length ripple of all ones plus one, alternating patterns with each carry-in value, and carries born just below each group boundary. The scenarios also show that results appear with no clock edge.

// File: rtl/tri_cla_adder.sv
module tri_cla_adder #(
  parameter int LEVELS = 3
) (
  input  logic [3**LEVELS-1:0] a,
  input  logic [3**LEVELS-1:0] b,
  input  logic                 cin,
  output logic [3**LEVELS-1:0] sum,
  output logic                 cout
);
  localparam int W  = 3**LEVELS;
  localparam int N1 = W / 3;
  localparam int N2 = W / 9;

  // returns {c_mid, c_top, grp_p, grp_g}
  function automatic logic [3:0] node3(input logic [2:0] p, input logic [2:0] g, input logic ci);
    logic c1, c2, gp, gg;
    c1 = g[0] | (p[0] & ci);
    c2 = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
    gg = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]);
    gp = p[2] & p[1] & p[0];
    return {c1, c2, gp, gg};
  endfunction

  logic [W-1:0]  bp, bg, bc;
  logic [N1-1:0] p1, g1, c1;
  logic [N2-1:0] p2, g2, c2;
  logic          rp, rg;

  assign bp  = a ^ b;
  assign bg  = a & b;
  assign sum = bp ^ bc;

  genvar k;
  generate
    for (k = 0; k < N1; k++) begin : g_lvl1
      logic [3:0] o;
      assign o = node3(bp[3*k +: 3], bg[3*k +: 3], c1[k]);
      assign bc[3*k]   = c1[k];
      assign bc[3*k+1] = o[3];
      assign bc[3*k+2] = o[2];
      assign p1[k]     = o[1];
      assign g1[k]     = o[0];
    end
    for (k = 0; k < N2; k++) begin : g_lvl2
      logic [3:0] o;
      assign o = node3(p1[3*k +: 3], g1[3*k +: 3], c2[k]);
      assign c1[3*k]   = c2[k];
      assign c1[3*k+1] = o[3];
      assign c1[3*k+2] = o[2];
      assign p2[k]     = o[1];
      assign g2[k]     = o[0];
    end
  endgenerate

  logic [3:0] ro;
  assign ro    = node3(p2, g2, cin);
  assign c2[0] = cin;
  assign c2[1] = ro[3];
  assign c2[2] = ro[2];
  assign rp    = ro[1];
  assign rg    = ro[0];
  assign cout  = rg | (rp & cin);

  always_comb begin
    a_r1_sum: assert (sum == W'({1'b0, a} + {1'b0, b} + (W+1)'(cin)))
      else $error("a_r1_sum");
    a_r2_cout: assert (cout == (({1'b0, a} + {1'b0, b} + (W+1)'(cin)) >> W))
      else $error("a_r2_cout");
    a_r7_prop: assert (!(&bp) || (cout == cin))
      else $error("a_r7_prop");
  end

  generate
    for (k = 1; k < N1; k++) begin : g_chk
      logic [W:0] part;
      assign part = {{(W-3*k+1){1'b0}}, a[3*k-1:0]} + {{(W-3*k+1){1'b0}}, b[3*k-1:0]} + (W+1)'(cin);
      if (k % 3 == 0) begin : g_nine
        always_comb
          a_r6_group9: assert (bc[3*k] == part[3*k]) else $error("a_r6_group9");
      end else begin : g_three
        always_comb
          a_r5_group3: assert (bc[3*k] == part[3*k]) else $error("a_r5_group3");
      end
    end
  endgenerate
endmodule

// File: tb/tri_cla_adder_bench.sv
module tri_cla_adder_bench;
  localparam int W = 27;
  logic clk = 0;
  logic [W-1:0] a = '0, b = '0, sum;
  logic cin = 0, cout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tri_cla_adder u_tri_cla_adder (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci, input string req);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cin = ci;
    #1;
    exp = {1'b0, x} + {1'b0, y} + (W+1)'(ci);
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d got cout=%0d sum=%h expected cout=%0d sum=%h",
               req, x, y, ci, cout, sum, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic t_zero; apply('0, '0, 1'b0, "R3 zero plus zero"); endtask

  task automatic t_full_ripple;
    apply('1, '0, 1'b1, "R4 all ones plus carry-in");
    apply('1, 27'd1, 1'b0, "R4 all ones plus one");
  endtask

  task automatic t_alternating;
    apply({14{2'b10}} >> 1, {14{2'b01}} >> 1, 1'b0, "R7 propagate cin=0");
    apply({14{2'b10}} >> 1, {14{2'b01}} >> 1, 1'b1, "R7 propagate cin=1");
    apply({14{2'b10}} >> 1, {14{2'b10}} >> 1, 1'b0, "R1 alternating equal cin=0");
    apply({14{2'b01}} >> 1, {14{2'b01}} >> 1, 1'b1, "R1 alternating equal cin=1");
  endtask

  task automatic t_group3;
    for (int k = 3; k < W; k += 3) begin
      apply(W'(1) << (k-1), W'(1) << (k-1), 1'b0, "R5 generate below 3-bit boundary");
      apply(W'((1 << k) - 1), '0, 1'b1, "R5 propagate run to 3-bit boundary");
    end
  endtask

  task automatic t_group9;
    apply(27'h1FF, 27'h001, 1'b0, "R6 carry into bit 9");
    apply(27'h3FFFF, 27'h0, 1'b1, "R6 carry into bit 18");
    apply(27'h0020000, 27'h0020000, 1'b0, "R6 generate at bit 17");
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1 R2 random");
  endtask

  task automatic t_no_clock;
    logic [W:0] exp;
    @(posedge clk);
    #0.5;
    a = 27'h5A5A5A5; b = 27'h2C3C3C3; cin = 1;
    #0.5;
    exp = {1'b0, a} + {1'b0, b} + 28'd1;
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL R8 combinational: got %h expected %h", {cout, sum}, exp);
    end
  endtask

  initial begin
    void'($urandom(7));
    t_zero();
    t_full_ripple();
    t_alternating();
    t_group3();
    t_group9();
    t_random();
    t_no_clock();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule